// File: doc/BRIEF.md
# Optical Carrier Modulator for a Serial Transmit Line

This block sits between the NRZ serial output of a UART transmitter and the output pin. Its job is to make that serial stream usable with an infrared or optical emitter. When modulation is switched on, every low (space) bit is replaced by a square-wave carrier. The carrier is derived from a fast reference clock that reaches the block as a one-cycle tick. Every high (mark) bit drives the pin to a steady low with no carrier, so the emitter is dark during idle and stop bits. When modulation is off, the serial bit reaches the pin unchanged and with no delay.

The carrier's half-period lasts a programmable number of reference ticks, equal to the divider plus one. The carrier frequency is therefore the reference rate divided by 2 × (divider + 1). A reference of 4096 to 8192 kHz covers carriers from roughly 30 to 60 kHz. After reset the divider holds the value that gives the carrier nearest 38 kHz for the configured reference rate. That value is 53 for a 4096 kHz reference, which gives about 37.9 kHz. A new divider value is loaded with a one-cycle write strobe.

The carrier starts again at every fall of the serial line. Each space bit therefore starts with a complete high half-period, and no remnant of an earlier bit carries over.

Top module: `opt_carrier_mod`

## Requirements
- R1: With `mod_en` = 0, `pin_out` equals `nrz_in` in the same cycle, whatever the state of the carrier.
- R2: With `mod_en` = 1 and `nrz_in` = 1, `pin_out` is 0.
- R3: With `mod_en` = 1 and `nrz_in` held at 0, and a tick on every cycle, `pin_out` is a square wave. It starts high and each level lasts divider + 1 cycles.
- R4: The first cycle of every space bit drives `pin_out` to 1 at once. This holds after each 1-to-0 change of `nrz_in`, and also when modulation is enabled while `nrz_in` is already 0. A full high half-period follows.
- R5: The carrier counts only on cycles where `ref_tick` is 1. With no ticks, `pin_out` holds its level during a space.
- R6: A cycle with `div_wr` = 1 loads `div_val` into the divider at the next clock edge. The new value sets the length of later half-periods.
- R7: If the divider is lowered below the count already reached in the current half-period, that half-period ends at the next tick.
- R8: Reset (`rst_n` = 0) puts the carrier in its start state (high), so the next space begins with a full high phase. Reset also loads the divider with the value nearest 38 kHz, which is 53 for the default 4096 kHz reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse at the reference clock rate |
| nrz_in | input | 1 | NRZ serial bit from the transmitter |
| mod_en | input | 1 | 1 = carrier modulation, 0 = plain pass-through |
| div_wr | input | 1 | Write strobe for the divider |
| div_val | input | DIV_W | New divider value (half-period = value + 1 ticks) |
| pin_out | output | 1 | Signal toward the output pin |

## Verification
A table of space runs is used first. Each run has a different divider (0, 3, 7, the reset value, and a disabled case) and a different length. The bench counts carrier rising edges and compares every cycle with the expected phase, so an error in the half-period length, the starting phase or the pass-through path each shows up differently. Directed sequences then cover a short mark between two spaces (the restart), spaces with the tick held off (the hold), and lowering the divider in the middle of a half-period. They also cover turning modulation off during a low carrier phase and the length of the first half-period after reset, which exposes a wrong default divider.

// File: rtl/cm_pkg.sv
package cm_pkg;

    // Half-period in reference ticks that best approximates the target carrier.
    function automatic int nearest_half(input int ref_khz, input int car_khz);
        return (ref_khz + car_khz) / (2 * car_khz);
    endfunction

endpackage

// File: rtl/cm_div_reg.sv
module cm_div_reg #(
    parameter int              DIV_W     = 8,
    parameter logic [DIV_W-1:0] RESET_DIV = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [DIV_W-1:0] wdata,
    output logic [DIV_W-1:0] div
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.div = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.div <= RESET_DIV;
        end else begin
            st_q <= st_d;
        end
    end

    assign div = st_q.div;
endmodule

// File: rtl/cm_carrier.sv
module cm_carrier #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             arm,
    input  logic [DIV_W-1:0] div,
    output logic             car
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             car;
    } car_st_t;

    car_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (arm) begin
            // Mark or bypass: park at the start of a high half-period.
            st_d.cnt = '0;
            st_d.car = 1'b1;
        end else if (tick) begin
            // >= so that lowering the divider mid-phase ends the phase at once.
            if (st_q.cnt >= div) begin
                st_d.cnt = '0;
                st_d.car = ~st_q.car;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.car <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign car = st_q.car;
endmodule

// File: rtl/cm_pin_mux.sv
module cm_pin_mux (
    input  logic mod_en,
    input  logic nrz,
    input  logic car,
    output logic pin
);
    always_comb begin
        if (mod_en) begin
            pin = ~nrz & car;
        end else begin
            pin = nrz;
        end
    end
endmodule

// File: rtl/opt_carrier_mod.sv
module opt_carrier_mod #(
    parameter int REF_KHZ         = 4096,
    parameter int DEF_CARRIER_KHZ = 38,
    parameter int DIV_W           = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             nrz_in,
    input  logic             mod_en,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_val,
    output logic             pin_out
);
    localparam int               DEF_HALF = cm_pkg::nearest_half(REF_KHZ, DEF_CARRIER_KHZ);
    localparam logic [DIV_W-1:0] DEF_DIV  = DIV_W'(DEF_HALF - 1);

    logic [DIV_W-1:0] div_w;
    logic             car_w;
    logic             arm_w;

    assign arm_w = nrz_in | ~mod_en;

    cm_div_reg #(
        .DIV_W     (DIV_W),
        .RESET_DIV (DEF_DIV)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (div_wr),
        .wdata (div_val),
        .div   (div_w)
    );

    cm_carrier #(
        .DIV_W (DIV_W)
    ) u_car (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ref_tick),
        .arm   (arm_w),
        .div   (div_w),
        .car   (car_w)
    );

    cm_pin_mux u_mux (
        .mod_en (mod_en),
        .nrz    (nrz_in),
        .car    (car_w),
        .pin    (pin_out)
    );
endmodule

// File: rtl/opt_carrier_mod_chk.sv
module opt_carrier_mod_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_tick,
    input logic             nrz_in,
    input logic             mod_en,
    input logic             div_wr,
    input logic [DIV_W-1:0] div_val,
    input logic             pin_out,
    input logic [DIV_W-1:0] div_q,
    input logic             car_q
);
    // R1
    bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |-> pin_out == nrz_in);

    // R2
    mark_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mod_en && nrz_in |-> !pin_out);

    // R4
    space_start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mod_en && !nrz_in && $past(nrz_in) |-> pin_out);

    // R5
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mod_en && !nrz_in && !ref_tick |=> $stable(car_q));

    // R3
    toggle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(car_q) |-> $past(ref_tick) || $past(nrz_in) || !$past(mod_en));

    // R6
    div_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> div_q == $past(div_val));
endmodule

bind opt_carrier_mod opt_carrier_mod_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .nrz_in   (nrz_in),
    .mod_en   (mod_en),
    .div_wr   (div_wr),
    .div_val  (div_val),
    .pin_out  (pin_out),
    .div_q    (div_w),
    .car_q    (car_w)
);

// File: tb/tb_opt_carrier_mod.sv
module tb_opt_carrier_mod;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b1;
    logic       nrz_in = 1'b1;
    logic       mod_en = 1'b1;
    logic       div_wr = 1'b0;
    logic [7:0] div_val = '0;
    logic       pin_out;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    opt_carrier_mod dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .nrz_in   (nrz_in),
        .mod_en   (mod_en),
        .div_wr   (div_wr),
        .div_val  (div_val),
        .pin_out  (pin_out)
    );

    // Table: enable, divider, space length, expected carrier rising edges.
    localparam int NV = 5;
    localparam int V_EN   [NV] = '{1, 1, 1, 0, 1};
    localparam int V_DIV  [NV] = '{3, 0, 53, 3, 7};
    localparam int V_LEN  [NV] = '{20, 10, 200, 20, 33};
    localparam int V_RISE [NV] = '{2, 4, 1, 0, 2};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle: drive after the falling edge, sample shortly after.
    task automatic cyc(input logic en, input logic nrz, input logic tk,
                       input logic wr, input logic [7:0] dv, output logic p);
        @(negedge clk);
        mod_en = en; nrz_in = nrz; ref_tick = tk; div_wr = wr; div_val = dv;
        #1 p = pin_out;
    endtask

    task automatic set_div(input logic [7:0] dv);
        logic p;
        cyc(1'b1, 1'b1, 1'b1, 1'b1, dv, p);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, dv, p);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic p, prev;
        int   bad, rises, hi_run;

        // R8: reset state, mark and space
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 8'd0, p);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 8'd0, p);
        chk(p == 1'b0, "R8 reset mark dark", int'(p), 0);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'd0, p);
        chk(p == 1'b1, "R8 reset carrier start high", int'(p), 1);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 8'd0, p);
        rst_n = 1'b1;
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 8'd0, p);
        chk(p == 1'b0, "R2 mark after reset", int'(p), 0);

        // R8: first half-period after reset uses the default divider (53 -> 54 cycles)
        hi_run = 0;
        for (int t = 0; t < 120; t++) begin
            cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'd0, p);
            if (p && hi_run == t) hi_run++;
        end
        chk(hi_run == 54, "R8 default divider half-period", hi_run, 54);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 8'd0, p);

        // R3 / R1 / R6: table of space runs
        for (int v = 0; v < NV; v++) begin
            set_div(8'(V_DIV[v]));
            bad = 0;
            rises = 0;
            prev = 1'b0;
            for (int t = 0; t < V_LEN[v]; t++) begin
                logic exp_p;
                cyc(1'(V_EN[v]), 1'b0, 1'b1, 1'b0, 8'd0, p);
                if (V_EN[v] != 0) exp_p = (((t / (V_DIV[v] + 1)) % 2) == 0);
                else              exp_p = 1'b0;
                if (p !== exp_p) bad++;
                if (t > 0 && p && !prev) rises++;
                prev = p;
            end
            chk(bad == 0, "R3 per-cycle carrier phase (R1 when disabled)", bad, 0);
            chk(rises == V_RISE[v], "R3 carrier rising edges", rises, V_RISE[v]);
            cyc(1'b1, 1'b1, 1'b1, 1'b0, 8'd0, p);
        end

        // R4: restart after a short mark
        set_div(8'd4);
        for (int t = 0; t < 7; t++) cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'd0, p);
        chk(p == 1'b0, "R4 low phase before mark", int'(p), 0);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 8'd0, p);
        chk(p == 1'b0, "R2 short mark dark", int'(p), 0);
        bad = 0;
        for (int t = 0; t < 6; t++) begin
            cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'd0, p);
            if (p !== (t < 5)) bad++;
        end
        chk(bad == 0, "R4 full high phase after restart", bad, 0);

        // R1: disable during a low phase, then re-enable within a space (R4)
        for (int t = 0; t < 4; t++) cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'd0, p);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 8'd0, p);
        chk(p == 1'b1, "R1 bypass passes mark", int'(p), 1);
        bad = 0;
        for (int t = 0; t < 8; t++) begin
            logic b;
            b = 1'((t * 5 + 1) % 3 == 0);
            cyc(1'b0, b, 1'b1, 1'b0, 8'd0, p);
            if (p !== b) bad++;
        end
        chk(bad == 0, "R1 bypass follows pattern", bad, 0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'd0, p);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'd0, p);
        chk(p == 1'b1, "R4 enable during space starts high", int'(p), 1);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 8'd0, p);

        // R5: no ticks -> carrier frozen
        set_div(8'd2);
        bad = 0;
        for (int t = 0; t < 10; t++) begin
            cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'd0, p);
            if (p !== 1'b1) bad++;
        end
        chk(bad == 0, "R5 hold without ticks", bad, 0);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'd0, p);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'd0, p);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'd0, p);
        chk(p == 1'b1, "R5 still high after two ticks", int'(p), 1);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'd0, p);
        chk(p == 1'b0, "R5 toggles after third tick", int'(p), 0);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 8'd0, p);

        // R7 / R6: lower divider mid half-period
        set_div(8'd20);
        for (int t = 0; t < 11; t++) cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'd0, p);
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 8'd3, p);
        chk(p == 1'b1, "R7 high before divider change", int'(p), 1);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'd3, p);
        chk(p == 1'b1, "R6 old divider used on load edge", int'(p), 1);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'd3, p);
        chk(p == 1'b0, "R7 phase ends at next tick", int'(p), 0);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 8'd0, p);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule